// File: doc/BRIEF.md
# Trigger-Marked Sample Timestamp Counter

This block keeps a running sample index for a receive IQ stream and stamps each outgoing packet header with it. An external trigger pin, asynchronous to the sample clock (a once-per-second pulse on a general-purpose input is the typical source), is watched for rising edges. When one arrives, the block records the index of the sample on which it arrived. It then marks the next packet header by setting the header's top bit, and that header carries the recorded event index in place of the packet's own start index. Software scanning headers therefore finds both the fact of the event and its exact sample position.

Two stream modes are supported. In dual-channel mode the index advances by one for every IQ pair. In single-channel mode an internal coarse counter advances once per two IQ pairs and is reported shifted up by one bit, so reported indices are always even. A separate sub-count bit records where the stream stands between coarse steps. Its value at the moment of the trigger is presented on a parity output, so the odd or even position of the event can still be recovered. The mode select is expected to change only while reset is held.

Top module: `trig_stamp_counter`

## Requirements
- R1: A synchronous active-high reset clears the sample count, the sub-count, any pending event, the header output and the parity output to zero. The first packet whose first sample is the first strobed sample after reset gets header 0.
- R2: In dual-channel mode (single_ch = 0), an unflagged header equals the number of iq_valid strobes accepted before the packet's first sample. Cycles with iq_valid low do not advance the count.
- R3: In single-channel mode (single_ch = 1), an unflagged header equals that same strobe count with bit 0 forced to 0. This is the count of completed pairs of samples shifted up by one bit, so header bit 0 is always 0.
- R4: A packet starts on a clock edge where pkt_start and iq_valid are both high. The first packet starting on an edge after the capture edge has bit 63 set. Its bits 62:0 hold the event index, reduced as in R3 when single_ch = 1. The event index is the strobe count before the first clock edge at which trig_raw is sampled high after being low. The capture edge comes two clock edges after that edge; this is the synchroniser latency, which the block compensates.
- R5: One trigger rising edge flags exactly one packet header. Later headers are unflagged until another rising edge arrives.
- R6: While trig_raw is held low, no header ever has bit 63 set.
- R7: A trigger held high for many cycles counts as one event and flags only one header.
- R8: In single-channel mode the parity output takes bit 0 of the event index at each capture and holds it until the next capture. In dual-channel mode a capture drives parity to 0.
- R9: pkt_start with iq_valid low starts no packet and leaves the header unchanged.
- R10: The header output holds its value between packet starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| iq_valid | input | 1 | One IQ pair accepted on this edge |
| single_ch | input | 1 | 1 = single-channel counting, 0 = dual-channel counting |
| trig_raw | input | 1 | Asynchronous external trigger pin |
| pkt_start | input | 1 | The strobed sample on this edge is the first of a new packet |
| hdr_ts | output | 64 | Packet header timestamp, bit 63 = event flag |
| parity | output | 1 | Odd/even position of the last captured event (single-channel mode) |

## Verification
The hardest situation to reach is a trigger edge that lands while the sub-count sits at an odd position in single-channel mode, close to a packet start. It is hardest when the capture edge and the packet edge coincide, so the flag must move on to the following packet. The stimulus reaches it by running long randomized phases in both modes from a fixed seed. In those phases iq_valid drops out irregularly, packets start often, and the trigger toggles with random spacing, so captures fall on both parities and against packet boundaries. Directed phases hold the trigger low and then high for hundreds of cycles to separate level from edge behaviour.

// File: rtl/ts_pkg.sv
package ts_pkg;

    // Header width; the top bit is the event flag.
    localparam int TS_W = 64;
    localparam int IDX_W = TS_W - 1;

    // Default synchroniser depth for the trigger pin.
    localparam int SYNC_DEF = 2;

    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        logic flag;
        idx_t idx;
    } hdr_t;

    typedef enum logic {
        MODE_DUAL   = 1'b0,
        MODE_SINGLE = 1'b1
    } mode_e;

    // Reported form of a full sample index: even-rounded in single mode.
    function automatic idx_t to_report(input idx_t full, input mode_e mode);
        idx_t r;
        r = full;
        if (mode == MODE_SINGLE) begin
            r[0] = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/ts_sample_counter.sv
module ts_sample_counter
    import ts_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  iq_valid,
    input  mode_e mode,
    output idx_t  full_idx
);

    // Coarse counter: per pair of samples in single mode, per sample in dual.
    idx_t cnt_q;
    logic sub_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sub_q <= 1'b0;
        end else if (iq_valid) begin
            if (mode == MODE_SINGLE) begin
                sub_q <= ~sub_q;
                if (sub_q) begin
                    cnt_q <= cnt_q + idx_t'(1);
                end
            end else begin
                cnt_q <= cnt_q + idx_t'(1);
                sub_q <= 1'b0;
            end
        end
    end

    // Full index: coarse count shifted up with the sub-count below it.
    assign full_idx = (mode == MODE_SINGLE) ? {cnt_q[IDX_W-2:0], sub_q} : cnt_q;

endmodule

// File: rtl/ts_trig_sync.sv
module ts_trig_sync
    import ts_pkg::*;
#(
    parameter int STAGES = SYNC_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_raw,
    input  idx_t cur_idx,
    output logic rise,
    output idx_t evt_idx
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;
    idx_t              tag_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], trig_raw};
            last_q <= sync_q[STAGES-1];
        end
    end

    // Index tags travel beside the synchroniser so the captured value is
    // the one current when the pin was first sampled high.
    for (genvar g = 0; g < STAGES; g++) begin : g_tag
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) tag_q[0] <= '0;
                else     tag_q[0] <= cur_idx;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) tag_q[g] <= '0;
                else     tag_q[g] <= tag_q[g-1];
            end
        end
    end

    assign rise    = sync_q[STAGES-1] & ~last_q;
    assign evt_idx = tag_q[STAGES-1];

endmodule

// File: rtl/ts_header_builder.sv
module ts_header_builder
    import ts_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pkt_fire,
    input  mode_e mode,
    input  idx_t  cur_idx,
    input  logic  rise,
    input  idx_t  evt_idx,
    output hdr_t  hdr,
    output logic  parity,
    output logic  pending
);

    hdr_t hdr_q;
    idx_t evt_q;
    logic pend_q;
    logic par_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q  <= '0;
            evt_q  <= '0;
            pend_q <= 1'b0;
            par_q  <= 1'b0;
        end else begin
            if (pkt_fire) begin
                if (pend_q) begin
                    hdr_q <= '{flag: 1'b1, idx: to_report(evt_q, mode)};
                end else begin
                    hdr_q <= '{flag: 1'b0, idx: to_report(cur_idx, mode)};
                end
            end
            if (rise) begin
                evt_q  <= evt_idx;
                pend_q <= 1'b1;
                par_q  <= (mode == MODE_SINGLE) & evt_idx[0];
            end else if (pkt_fire) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign hdr     = hdr_q;
    assign parity  = par_q;
    assign pending = pend_q;

endmodule

// File: rtl/trig_stamp_counter.sv
module trig_stamp_counter
    import ts_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            iq_valid,
    input  logic            single_ch,
    input  logic            trig_raw,
    input  logic            pkt_start,
    output logic [TS_W-1:0] hdr_ts,
    output logic            parity
);

    mode_e mode;
    idx_t  cur_idx;
    idx_t  evt_idx;
    logic  rise;
    logic  pend_w;
    logic  pkt_fire;
    hdr_t  hdr_w;

    assign mode     = single_ch ? MODE_SINGLE : MODE_DUAL;
    assign pkt_fire = pkt_start & iq_valid;

    ts_sample_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .iq_valid (iq_valid),
        .mode     (mode),
        .full_idx (cur_idx)
    );

    ts_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .trig_raw (trig_raw),
        .cur_idx  (cur_idx),
        .rise     (rise),
        .evt_idx  (evt_idx)
    );

    ts_header_builder u_hdr (
        .clk      (clk),
        .rst      (rst),
        .pkt_fire (pkt_fire),
        .mode     (mode),
        .cur_idx  (cur_idx),
        .rise     (rise),
        .evt_idx  (evt_idx),
        .hdr      (hdr_w),
        .parity   (parity),
        .pending  (pend_w)
    );

    assign hdr_ts = hdr_w;

endmodule

// File: rtl/trig_stamp_checker.sv
module trig_stamp_checker
    import ts_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            iq_valid,
    input logic            pkt_start,
    input logic            single_ch,
    input logic [TS_W-1:0] hdr_ts,
    input logic            parity,
    input logic            capture,
    input logic            pending,
    input idx_t            cur_idx
);

    logic fire;
    assign fire = pkt_start & iq_valid;

    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        !iq_valid |=> $stable(cur_idx)); // R2

    AST_SINGLE_EVEN: assert property (@(posedge clk) disable iff (rst)
        (single_ch && fire) |=> !hdr_ts[0]); // R3

    AST_FLAG_ON_PENDING: assert property (@(posedge clk) disable iff (rst)
        (fire && pending) |=> hdr_ts[TS_W-1]); // R4

    AST_FLAG_ONCE: assert property (@(posedge clk) disable iff (rst)
        (fire && pending && !capture) |=> !pending); // R5

    AST_NO_FLAG_IDLE: assert property (@(posedge clk) disable iff (rst)
        (fire && !pending) |=> !hdr_ts[TS_W-1]); // R6

    AST_DUAL_PARITY: assert property (@(posedge clk) disable iff (rst)
        (!single_ch && capture) |=> !parity); // R8

    AST_HDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(hdr_ts)); // R10

endmodule

bind trig_stamp_counter trig_stamp_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .iq_valid  (iq_valid),
    .pkt_start (pkt_start),
    .single_ch (single_ch),
    .hdr_ts    (hdr_ts),
    .parity    (parity),
    .capture   (rise),
    .pending   (pend_w),
    .cur_idx   (cur_idx)
);

// File: tb/trig_stamp_counter_bench.sv
module trig_stamp_counter_bench;

    logic        clk = 1'b0;
    logic        rst, iq_valid, single_ch, trig_raw, pkt_start;
    logic [63:0] hdr_ts;
    logic        parity;

    always #5 clk = ~clk;

    trig_stamp_counter u_trig_stamp_counter (
        .clk(clk), .rst(rst), .iq_valid(iq_valid), .single_ch(single_ch),
        .trig_raw(trig_raw), .pkt_start(pkt_start), .hdr_ts(hdr_ts), .parity(parity)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Bench model state
    logic [63:0] n_m, evt_m, cap_m, hdr_m;
    bit          pend_m, par_m, prev_trig;
    int          cd;
    int          flags_seen;

    function automatic logic [62:0] rep(input logic [63:0] v, input bit s);
        logic [62:0] r;
        r = v[62:0];
        if (s) r[0] = 1'b0;
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit s);
        rst = 1'b1; iq_valid = 0; pkt_start = 0; trig_raw = 0; single_ch = s;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        n_m = 0; evt_m = 0; cap_m = 0; hdr_m = 0;
        pend_m = 0; par_m = 0; prev_trig = 0; cd = 0;
    endtask

    task automatic cyc(input bit v, input bit p, input bit t);
        bit capture, fire;
        string tag;
        iq_valid = v; pkt_start = p; trig_raw = t;
        @(posedge clk);
        capture = 0;
        if (cd == 1) capture = 1;
        if (cd > 0) cd--;
        if (t && !prev_trig) begin cd = 2; cap_m = n_m; end
        prev_trig = t;
        fire = v && p;
        if (fire) begin
            if (pend_m) hdr_m = {1'b1, rep(evt_m, single_ch)};
            else        hdr_m = {1'b0, rep(n_m, single_ch)};
        end
        if (capture) begin
            evt_m = cap_m; pend_m = 1; par_m = single_ch & cap_m[0];
        end else if (fire) begin
            pend_m = 0;
        end
        if (v) n_m++;
        @(negedge clk);
        if (fire && hdr_ts[63]) flags_seen++;
        if (fire && hdr_m[63])     tag = "R4";
        else if (fire && single_ch) tag = "R3";
        else if (fire)              tag = "R2";
        else if (p)                 tag = "R9";
        else                        tag = "R10";
        chk(hdr_ts === hdr_m, tag, hdr_ts, hdr_m);
        if (capture) chk(parity === par_m, "R8", {63'd0, parity}, {63'd0, par_m});
    endtask

    task automatic random_phase(input bit s, input int len);
        int tcnt;
        bit t;
        do_reset(s);
        t = 0; tcnt = 5;
        for (int i = 0; i < len; i++) begin
            tcnt--;
            if (tcnt <= 0) begin t = ~t; tcnt = 4 + int'($urandom % 40); end
            cyc(($urandom % 4) != 0, ($urandom % 12) == 0, t);
        end
        cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset(0);
        // R1: reset state
        chk(hdr_ts === 64'd0, "R1 header", hdr_ts, 64'd0);
        chk(parity === 1'b0, "R1 parity", {63'd0, parity}, 64'd0);
        cyc(1, 1, 0);
        chk(hdr_ts === 64'd0, "R1 first packet", hdr_ts, 64'd0);

        // R9: pkt_start without a sample
        repeat (5) cyc(1, 0, 0);
        cyc(0, 1, 0);
        chk(hdr_ts === 64'd0, "R9 ignored start", hdr_ts, 64'd0);

        // R6: trigger held low in both modes
        for (int s = 0; s < 2; s++) begin
            do_reset(s[0]);
            flags_seen = 0;
            for (int i = 0; i < 300; i++) cyc(1, (i % 7) == 0, 0);
            chk(flags_seen == 0, "R6 no flag", 64'(flags_seen), 64'd0);
        end

        // R7: trigger held high marks one header
        do_reset(0);
        flags_seen = 0;
        repeat (10) cyc(1, 0, 0);
        for (int i = 0; i < 300; i++) cyc(1, (i % 5) == 0, 1);
        chk(flags_seen == 1, "R7 held high", 64'(flags_seen), 64'd1);

        // R5: single pulse, many packets afterwards; odd event index in single mode
        do_reset(1);
        flags_seen = 0;
        repeat (7) cyc(1, 0, 0);
        cyc(1, 0, 1); cyc(1, 0, 1); cyc(1, 0, 0); cyc(1, 0, 0);
        chk(parity === 1'b1, "R8 odd event", {63'd0, parity}, 64'd1);
        for (int i = 0; i < 60; i++) cyc(1, (i % 4) == 0, 0);
        chk(flags_seen == 1, "R5 one flag", 64'(flags_seen), 64'd1);

        // R4: capture edge and packet edge coincide, flag moves to next packet
        do_reset(0);
        flags_seen = 0;
        repeat (3) cyc(1, 0, 0);
        cyc(1, 0, 1); cyc(1, 0, 1); cyc(1, 1, 1);
        chk(hdr_ts[63] === 1'b0, "R4 coincident packet unflagged", hdr_ts, 64'd3 + 2);
        cyc(1, 1, 1);
        chk(hdr_ts === {1'b1, 63'd3}, "R4 event index", hdr_ts, {1'b1, 63'd3});

        random_phase(0, 5000);
        random_phase(1, 5000);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule